// File: doc/BRIEF.md
# Serial Register Slave for a Frequency Synthesizer

This block connects a frequency synthesizer to a two-wire serial bus as an I2C-compatible slave. It samples the bus clock and data lines with the system clock and recognises START and STOP conditions. It answers a 7-bit address whose upper five bits are fixed at `11000`. The two lowest address bits come from a board strap, so four synthesizers can share one bus. The slave acknowledges by pulling SDA low through an open-drain enable. It never stretches the clock and does not support 10-bit addressing.

In a write transfer, the first bit of each data byte decides what the byte is. A byte that starts with 0 carries the upper divider bits. The byte after it carries the lower eight divider bits, and the two are committed together. A byte that starts with 1 is the control byte, and the byte after it is taken as the band-switch byte. Bytes can keep arriving until STOP without a new address. A transfer that is cut short leaves every value that was already committed in place.

In a read transfer, the slave sends a status byte MSB first. The byte carries the power-up flag, the lock flag, three fixed ones and a 3-bit level code. The power-up flag reads 1 until one complete status byte has been sent. After that it reads 0.

Top module: `synth_i2c_slave`

## Requirements
- R1: After synchronous reset, `div_word`, `ctrl_word` and `band_word` are all zero, and `sda_oe` is low. The power-up flag is set, so the first status byte read has bit 7 = 1.
- R2: An address byte equal to `{5'b11000, strap_i[1:0], rw}` is acknowledged. `sda_oe` is high from the SCL falling edge after the eighth bit until the next SCL falling edge. `sda_oe` only rises while SCL is low.
- R3: An address byte that does not match gets no acknowledge. After it, no register changes and SDA is not driven until the next START.
- R4: A data byte whose bit 7 is 0 holds divider bits [14:8] in its bits [6:0]. The byte after it is always taken as divider bits [7:0], even when its own bit 7 is 1. `div_word` changes only when that second byte completes.
- R5: A data byte whose bit 7 is 1, arriving when no divider pair and no band byte are pending, sets `ctrl_word` to its bits [6:0] once the byte completes.
- R6: The byte after a control byte is the band byte, whatever its bit 7. `band_word` takes its bits [3:0].
- R7: Any number of data bytes can follow one address in a single write transfer. Each byte is sorted by the rules in R4 to R6.
- R8: A STOP or a repeated START discards a pending upper divider byte, and `div_word` keeps its old value. The next data byte is sorted afresh by its bit 7.
- R9: In a read, the status byte is `{por, lock_i, 1, 1, 1, level_i[2:0]}`, sent MSB first. If the master acknowledges, the slave sends the status byte again.
- R10: The power-up flag is cleared once a whole status byte has been sent. Later reads show bit 7 = 0.
- R11: Every data byte received in a write transfer to this slave is acknowledged.
- R12: After the master answers a status byte with a not-acknowledge, the slave releases SDA and stays off the bus until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Address strap giving the two lowest address bits |
| lock_i | input | 1 | Synthesizer lock indication, reported in the status byte |
| level_i | input | 3 | Level code reported in the status byte |
| div_word | output | 15 | Committed divider ratio |
| ctrl_word | output | 7 | Committed control bits: pump current, test code, reference select, amplifier off |
| band_word | output | 4 | Committed band-switch outputs |

## Verification
A single write transfer of twelve bytes covers several cases:
- A low divider byte whose bit 7 is 1. A design that sorted it by its first bit would load the control register instead of completing the divider.
- A band byte whose bit 7 is 0. A design that sorted it by its first bit would open a new divider pair.
- Register values checked between the upper and lower divider bytes. A design that committed the upper half early would show a half-updated divider here.

A STOP after a lone upper byte, and a repeated START followed by a control byte, show whether a stale pending byte is wrongly merged with new data. Two reads cover the flags. The first catches a power-up flag that is not set at reset. The second catches one that is never cleared, or cleared too early. A wrong strap address and a master not-acknowledge show whether the slave drives SDA when it should stay off the bus.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

  // Bus-side protocol phases of the byte engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK,
    PH_WRITE,
    PH_SEND,
    PH_MACK,
    PH_SKIP
  } bus_phase_t;

  // What the register sorter expects from the next data byte
  typedef enum logic [1:0] {
    EXP_ANY,
    EXP_DIV_LO,
    EXP_BAND
  } expect_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_i2c_pkg::*;
#(
  parameter int          ADDR_FIX_W = 5,
  parameter logic [ADDR_FIX_W-1:0] ADDR_FIX = 5'b11000,
  parameter int          STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [7:0]         status_byte,
  output logic               sda_oe,
  output logic               byte_stb,
  output logic [7:0]         byte_data,
  output logic               txn_reset,
  output logic               status_sent
);

  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] FULL     = 4'd8;

  bus_phase_t phase;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rw_q;
  logic       nack_q;
  logic       addr_hit;

  assign addr_hit = (rx_sh[7:1] == {ADDR_FIX, strap_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rw_q        <= 1'b0;
      nack_q      <= 1'b0;
      sda_oe      <= 1'b0;
      byte_stb    <= 1'b0;
      byte_data   <= '0;
      txn_reset   <= 1'b0;
      status_sent <= 1'b0;
    end else begin
      byte_stb    <= 1'b0;
      txn_reset   <= 1'b0;
      status_sent <= 1'b0;
      if (start_det) begin
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        txn_reset <= 1'b1;
      end else if (stop_det) begin
        phase     <= PH_IDLE;
        sda_oe    <= 1'b0;
        txn_reset <= 1'b1;
      end else begin
        case (phase)
          PH_ADDR, PH_WRITE: begin
            if (scl_rise && bit_cnt != FULL) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (phase == PH_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw_q   <= rx_sh[0];
                  phase  <= PH_ACK;
                end else begin
                  phase  <= PH_SKIP;
                end
              end else begin
                byte_stb  <= 1'b1;
                byte_data <= rx_sh;
                sda_oe    <= 1'b1;
                rw_q      <= 1'b0;
                phase     <= PH_ACK;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                sda_oe <= ~status_byte[7];
                tx_sh  <= {status_byte[6:0], 1'b0};
                phase  <= PH_SEND;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_WRITE;
              end
            end
          end
          PH_SEND: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe      <= 1'b0;
                status_sent <= 1'b1;
                nack_q      <= 1'b1;
                phase       <= PH_MACK;
              end else begin
                sda_oe  <= ~tx_sh[7];
                tx_sh   <= {tx_sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (nack_q) begin
                phase <= PH_SKIP;
              end else begin
                sda_oe <= ~status_byte[7];
                tx_sh  <= {status_byte[6:0], 1'b0};
                phase  <= PH_SEND;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/synth_reg_sorter.sv
module synth_reg_sorter
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int BAND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              txn_reset,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [BAND_W-1:0] band_word
);

  localparam int HI_W = DIV_W - 8;

  expect_t         want;
  logic [HI_W-1:0] div_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_word  <= '0;
      ctrl_word <= '0;
      band_word <= '0;
      div_hi    <= '0;
      want      <= EXP_ANY;
    end else if (txn_reset) begin
      want <= EXP_ANY;
    end else if (byte_stb) begin
      case (want)
        EXP_DIV_LO: begin
          div_word <= {div_hi, byte_data};
          want     <= EXP_ANY;
        end
        EXP_BAND: begin
          band_word <= byte_data[BAND_W-1:0];
          want      <= EXP_ANY;
        end
        default: begin
          if (byte_data[7]) begin
            ctrl_word <= byte_data[CTRL_W-1:0];
            want      <= EXP_BAND;
          end else begin
            div_hi <= byte_data[HI_W-1:0];
            want   <= EXP_DIV_LO;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/synth_status_word.sv
module synth_status_word #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             status_sent,
  output logic [7:0]       status_byte
);

  localparam int FILL_W = 8 - 2 - LVL_W;

  logic             por_q;
  logic             lock_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q   <= 1'b1;
      lock_q  <= 1'b0;
      level_q <= '0;
    end else begin
      lock_q  <= lock_i;
      level_q <= level_i;
      if (status_sent) por_q <= 1'b0;
    end
  end

  assign status_byte = {por_q, lock_q, {FILL_W{1'b1}}, level_q};

endmodule

// File: rtl/synth_i2c_slave.sv
module synth_i2c_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int CTRL_W      = 7,
  parameter int BAND_W      = 4,
  parameter int LVL_W       = 3,
  parameter int STRAP_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic              lock_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [BAND_W-1:0] band_word
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_stb, txn_reset, status_sent;
  logic [7:0] byte_data, status_byte;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.STRAP_W(STRAP_W)) u_engine (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap_i(strap_i), .status_byte(status_byte), .sda_oe(sda_oe),
    .byte_stb(byte_stb), .byte_data(byte_data), .txn_reset(txn_reset),
    .status_sent(status_sent)
  );

  synth_reg_sorter #(.DIV_W(DIV_W), .CTRL_W(CTRL_W), .BAND_W(BAND_W)) u_sorter (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_data(byte_data),
    .txn_reset(txn_reset), .div_word(div_word), .ctrl_word(ctrl_word),
    .band_word(band_word)
  );

  synth_status_word #(.LVL_W(LVL_W)) u_status (
    .clk(clk), .rst(rst), .lock_i(lock_i), .level_i(level_i),
    .status_sent(status_sent), .status_byte(status_byte)
  );

endmodule

// File: rtl/synth_i2c_slave_chk.sv
module synth_i2c_slave_chk #(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int BAND_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              byte_stb,
  input logic [7:0]        byte_data,
  input logic [DIV_W-1:0]  div_word,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [BAND_W-1:0] band_word
);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!sda_oe && div_word == '0 && ctrl_word == '0 && band_word == '0)); // R1

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s); // R2

  AST_DIV_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_word) |-> $past(byte_stb)); // R4

  AST_CTRL_ON_MARKED_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_word) |-> $past(byte_stb && byte_data[7])); // R5

  AST_BAND_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_word) |-> $past(byte_stb)); // R6

endmodule

bind synth_i2c_slave synth_i2c_slave_chk #(
  .DIV_W(DIV_W), .CTRL_W(CTRL_W), .BAND_W(BAND_W)
) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
  .byte_stb(byte_stb), .byte_data(byte_data), .div_word(div_word),
  .ctrl_word(ctrl_word), .band_word(band_word)
);

// File: tb/synth_i2c_slave_test.sv
`timescale 1ns/1ps
module synth_i2c_slave_test;

  localparam int Q = 10;
  localparam int NVEC = 12;
  // {byte, expected div, expected ctrl, expected band}
  localparam logic [33:0] VECS [NVEC] = '{
    {8'h12, 15'h0000, 7'h00, 4'h0},
    {8'h34, 15'h1234, 7'h00, 4'h0},
    {8'hA5, 15'h1234, 7'h25, 4'h0},
    {8'h0B, 15'h1234, 7'h25, 4'hB},
    {8'h7F, 15'h1234, 7'h25, 4'hB},
    {8'hFF, 15'h7FFF, 7'h25, 4'hB},
    {8'hC0, 15'h7FFF, 7'h40, 4'hB},
    {8'hF6, 15'h7FFF, 7'h40, 4'h6},
    {8'h01, 15'h7FFF, 7'h40, 4'h6},
    {8'h80, 15'h0180, 7'h40, 4'h6},
    {8'h9E, 15'h0180, 7'h1E, 4'h6},
    {8'h05, 15'h0180, 7'h1E, 4'h5}
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        scl_m = 1;
  logic        sda_m = 1;
  logic        sda_oe;
  logic [1:0]  strap = 2'b10;
  logic        lock = 0;
  logic [2:0]  level = 3'b000;
  logic [14:0] div_word;
  logic [6:0]  ctrl_word;
  logic [3:0]  band_word;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_i2c_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .lock_i(lock), .level_i(level), .div_word(div_word),
    .ctrl_word(ctrl_word), .band_word(band_word)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; qwait; scl_m = 1; qwait; sda_m = 0; qwait; scl_m = 0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 0; qwait; scl_m = 1; qwait; sda_m = 1; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait; scl_m = 1; qwait; qwait; scl_m = 0; qwait;
    end
    sda_m = 1; qwait; scl_m = 1; qwait; ack = ~sda_line; qwait; scl_m = 0; qwait;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b, output logic drove);
    drove = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; qwait; scl_m = 1; qwait; b[i] = sda_line; if (sda_oe) drove = 1;
      qwait; scl_m = 0; qwait;
    end
    sda_m = ~master_ack; qwait; scl_m = 1; qwait; qwait; scl_m = 0; sda_m = 1; qwait;
  endtask

  initial begin
    logic       ack;
    logic       drove;
    logic [7:0] rd;
    logic [33:0] v;

    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    check("R1 div after reset", div_word, 0);
    check("R1 ctrl after reset", ctrl_word, 0);
    check("R1 band after reset", band_word, 0);
    check("R1 sda_oe after reset", sda_oe, 0);

    // First read: power-up flag set
    lock = 1; level = 3'b101;
    qwait;
    bus_start;
    send_byte(8'hC5, ack);
    check("R2 read address ack", ack, 1);
    recv_byte(1'b0, rd, drove);
    check("R1 R9 status with power-up flag", rd, 8'hFD);
    recv_byte(1'b0, rd, drove);
    check("R12 released after nack", rd, 8'hFF);
    check("R12 no drive after nack", drove, 0);
    bus_stop;

    // Table-driven write transfer: R4 R5 R6 R7 R11
    bus_start;
    send_byte(8'hC4, ack);
    check("R2 write address ack", ack, 1);
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      send_byte(v[33:26], ack);
      check("R11 data byte ack", ack, 1);
      check("R4 R7 divider", div_word, v[25:11]);
      check("R5 R7 control", ctrl_word, v[10:4]);
      check("R6 R7 band", band_word, v[3:0]);
    end
    bus_stop;

    // R8: STOP after lone upper byte
    bus_start;
    send_byte(8'hC4, ack);
    send_byte(8'h33, ack);
    bus_stop;
    check("R8 div kept after stop", div_word, 15'h0180);
    // R8: repeated START discards pending byte
    bus_start;
    send_byte(8'hC4, ack);
    send_byte(8'h22, ack);
    bus_start;
    send_byte(8'hC4, ack);
    send_byte(8'h91, ack);
    check("R8 div kept after restart", div_word, 15'h0180);
    check("R8 byte after restart is control", ctrl_word, 7'h11);
    send_byte(8'h03, ack);
    check("R8 R6 band after restart", band_word, 4'h3);
    bus_stop;

    // R3: wrong address
    bus_start;
    send_byte(8'hC0, ack);
    check("R3 no ack on mismatch", ack, 0);
    send_byte(8'h01, ack);
    check("R3 no ack on ignored byte", ack, 0);
    send_byte(8'h23, ack);
    check("R3 no ack on ignored byte 2", ack, 0);
    check("R3 div untouched", div_word, 15'h0180);
    check("R3 band untouched", band_word, 4'h3);
    bus_stop;

    // Second read: power-up flag cleared, repeat on master ack
    lock = 0; level = 3'b010;
    qwait;
    bus_start;
    send_byte(8'hC5, ack);
    check("R2 second read ack", ack, 1);
    recv_byte(1'b1, rd, drove);
    check("R10 status after clear", rd, 8'h3A);
    recv_byte(1'b0, rd, drove);
    check("R9 repeated status", rd, 8'h3A);
    recv_byte(1'b0, rd, drove);
    check("R12 no drive after second nack", drove, 0);
    bus_stop;
    check("R12 sda released at end", sda_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule